// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbiter

This block holds a bank of CAN message mailboxes and decides which pending transmit mailbox is handed to the bit-level controller next. A CPU port writes and reads each mailbox's control word and identifier word. It also clears event flags and sets interrupt mask bits. The controller reports the current frame phase. Certain phase events start a scan, which visits one mailbox per clock. At the end of the scan, the winning mailbox is copied into a hidden serial buffer and presented on the move-out outputs. If nothing is pending, a "no winner" indication is raised instead.

The scan uses one of two priority orders, chosen by a mode input. In identifier order, the key is built from the identifier with the remote and extended bits placed where they travel on the wire. In index order, the lowest-numbered pending mailbox wins. A CPU write to a control word takes that mailbox out of play at once. When the controller reports a successful send, the block finishes the mailbox: it stores a timestamp, retires the code, sets the mailbox's flag, and raises the interrupt through the mask.

Top module: `canTxMailboxArbiter`

## Requirements
- R1: After reset, every mailbox reads back as zero, and the flag and mask words are zero. `moValid`, `noWinner`, `scanBusy` and `irq` are all low.
- R2: The identifier-order key and its comparison work as follows:
  - The mode is identifier order when `idxPriority`=0.
  - For standard frames (IDE=0), the key is {ID[28:18], RTR, 0, 18'b0, 0}.
  - For extended frames (IDE=1), the key is {ID[28:18], 1, 1, ID[17:0], RTR}.
  - The pending mailbox with the numerically smallest key wins.
- R3: With `idxPriority`=1, the lowest-numbered pending mailbox wins, whatever its identifier.
- R4: Only mailboxes whose code is 4'b1100 (transmit pending) take part in a scan. Code 4'b0000 (inactive), code 4'b1000 (idle or empty) and every other code are passed over.
- R5: When two pending mailboxes have equal keys, the lower index wins.
- R6: A scan starts on the clock edge at which `phase` enters 2 (CRC field) or enters 3 (error delimiter).
- R7: Entering `phase` 4 (intermission) starts a scan in only two cases:
  - the previous winner was dropped by a CPU write; or
  - the last scan found no winner and a control word has been written since that scan started.
- R8: A control-word write while `phase` is 0 (idle) or 5 (bus-off) starts a scan. Leaving `phase` 6 (freeze) for any other phase also starts a scan.
- R9: `scanBusy` is high for exactly 16 cycles after the start edge. The result appears on the edge that ends the scan, which is the 17th edge counting the start edge.
- R10: A CPU write to a control word has two immediate effects on its mailbox:
  - If the mailbox is the currently moved-out winner, `moValid` clears on the next edge.
  - If the mailbox is the best candidate of a scan in progress, the scan restarts from mailbox 0.
- R11: The move-out outputs carry the winner's index, its 29-bit identifier, IDE and RTR. `moBytes` is the DLC limited to 8.
- R12: `txDone` while `moValid` is high has four effects on the moved-out mailbox:
  - `timerVal` is written into its timestamp;
  - its code is set to 4'b1000;
  - its flag bit is set;
  - `moValid` clears.
- R13: `irq` is high exactly when some flag bit and its mask bit are both 1. Writing 1 to a flag bit (select 2) clears it. Mask bits are written with select 3.
- R14: A scan that finds no pending mailbox raises `noWinner` and clears `moValid`. A scan that finds one clears `noWinner`.

Register encoding:
- Select 0 is the control word: DLC[3:0], code[7:4], IDE[8], RTR[9], timestamp[31:16]. The timestamp is read-only.
- Select 1 is the identifier word: ID[28:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idxPriority | input | 1 | 1: index order, 0: identifier order |
| phase | input | 3 | Frame phase from the bit-level controller |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuSel | input | 2 | Word select: 0 control, 1 identifier, 2 flags, 3 masks |
| cpuMbx | input | 4 | Mailbox index for the CPU access |
| cpuWrData | input | 32 | CPU write data |
| cpuRdData | output | 32 | Read data for the current cpuSel and cpuMbx |
| timerVal | input | 16 | Free-running timer value |
| txDone | input | 1 | Pulse: the moved-out frame was sent |
| scanBusy | output | 1 | Scan in progress |
| moValid | output | 1 | Serial buffer holds a winner |
| moMbx | output | 4 | Index of the moved-out mailbox |
| moId | output | 29 | Identifier of the moved-out mailbox |
| moIde | output | 1 | Extended-frame bit of the winner |
| moRtr | output | 1 | Remote-frame bit of the winner |
| moBytes | output | 4 | Data bytes to send (DLC limited to 8) |
| noWinner | output | 1 | Last scan found nothing pending |
| irq | output | 1 | Masked interrupt |

## Verification
Random mailbox banks are used in both priority modes. In these banks the pending code is mixed with idle, inactive and odd codes, so mode confusion and filtering mistakes lead to a different winner. Directed banks separate the finer cases:
- the standard and extended form of the same base identifier, which tests where IDE sits in the key;
- data and remote frames with one identifier, which tests where RTR sits;
- equal keys at two indices, which tests the tie rule.

The scan triggers are tested by stepping through each phase event both with and without its enabling condition. A mid-scan write to the current best candidate checks that the scan restarts instead of handing out a stale winner.

// File: rtl/canArbPkg.sv
`timescale 1ns/1ps
package canArbPkg;
  parameter int MBX_COUNT = 16;
  localparam int MBX_IDX_W = $clog2(MBX_COUNT);
  localparam int ID_W = 29;
  localparam int BASE_W = 11;
  localparam int EXT_W = ID_W - BASE_W;
  localparam int KEY_W = ID_W + 3;
  localparam int TS_W = 16;
  localparam int DLC_W = 4;
  localparam int CODE_W = 4;
  localparam int WORD_W = 32;
  localparam logic [DLC_W-1:0] MAX_BYTES = DLC_W'(8);

  localparam int DLC_LSB = 0;
  localparam int CODE_LSB = 4;
  localparam int IDE_BIT = 8;
  localparam int RTR_BIT = 9;
  localparam int TS_LSB = 16;

  localparam logic [CODE_W-1:0] CODE_INACTIVE = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_TX_IDLE = 4'b1000;
  localparam logic [CODE_W-1:0] CODE_TX_PEND = 4'b1100;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ID = 2'd1;
  localparam logic [1:0] SEL_FLAG = 2'd2;
  localparam logic [1:0] SEL_MASK = 2'd3;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_FIELD = 3'd1,
    PH_CRC = 3'd2,
    PH_ERRDELIM = 3'd3,
    PH_INTER = 3'd4,
    PH_BUSOFF = 3'd5,
    PH_FREEZE = 3'd6
  } phaseT;

  typedef struct packed {
    logic scanClear;
    logic scanStep;
    logic scanFinish;
    logic [MBX_IDX_W-1:0] scanIdx;
    logic moDrop;
    logic wbEn;
  } strobeT;

  // Priority key laid out in on-wire bit order; smaller wins.
  function automatic logic [KEY_W-1:0] wireKey(input logic [ID_W-1:0] id,
                                               input logic ide, input logic rtr);
    if (ide) wireKey = {id[ID_W-1:EXT_W], 1'b1, 1'b1, id[EXT_W-1:0], rtr};
    else     wireKey = {id[ID_W-1:EXT_W], rtr, 1'b0, {EXT_W{1'b0}}, 1'b0};
  endfunction
endpackage

// File: rtl/mbxControl.sv
`timescale 1ns/1ps
module mbxControl
  import canArbPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  phaseT                phase,
  input  logic                 cpuWrEn,
  input  logic [1:0]           cpuSel,
  input  logic [MBX_IDX_W-1:0] cpuMbx,
  input  logic                 txDone,
  input  logic                 bestValid,
  input  logic [MBX_IDX_W-1:0] bestIdx,
  input  logic                 moValid,
  input  logic [MBX_IDX_W-1:0] moMbx,
  input  logic                 noWinner,
  output strobeT               st,
  output logic                 scanBusy
);
  localparam logic [MBX_IDX_W-1:0] LAST_IDX = MBX_IDX_W'(MBX_COUNT - 1);

  phaseT phasePrev;
  logic scanActive;
  logic [MBX_IDX_W-1:0] scanCnt;
  logic winnerGone;
  logic wroteSince;

  logic ctrlWr, enterCrc, enterErr, enterInter, leaveFreeze, idleWrite;
  logic trigger, restart, startScan, dropHit;

  always_comb begin
    ctrlWr      = cpuWrEn && (cpuSel == SEL_CTRL);
    enterCrc    = (phase == PH_CRC) && (phasePrev != PH_CRC);
    enterErr    = (phase == PH_ERRDELIM) && (phasePrev != PH_ERRDELIM);
    enterInter  = (phase == PH_INTER) && (phasePrev != PH_INTER);
    leaveFreeze = (phasePrev == PH_FREEZE) && (phase != PH_FREEZE);
    idleWrite   = ctrlWr && ((phase == PH_IDLE) || (phase == PH_BUSOFF));
    trigger = enterCrc || enterErr || leaveFreeze || idleWrite ||
              (enterInter && (winnerGone || (noWinner && wroteSince)));
    restart   = scanActive && ctrlWr && bestValid && (cpuMbx == bestIdx);
    startScan = trigger || restart;
    dropHit   = ctrlWr && moValid && (cpuMbx == moMbx);

    st.scanClear  = startScan;
    st.scanStep   = scanActive && !startScan;
    st.scanIdx    = scanCnt;
    st.scanFinish = scanActive && !startScan && (scanCnt == LAST_IDX);
    st.moDrop     = dropHit;
    st.wbEn       = txDone && moValid && !dropHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phasePrev  <= PH_IDLE;
      scanActive <= 1'b0;
      scanCnt    <= '0;
      winnerGone <= 1'b0;
      wroteSince <= 1'b0;
    end else begin
      phasePrev <= phase;
      if (startScan) begin
        scanActive <= 1'b1;
        scanCnt    <= '0;
      end else if (scanActive) begin
        scanCnt <= scanCnt + 1'b1;
        if (scanCnt == LAST_IDX) scanActive <= 1'b0;
      end
      if (startScan) winnerGone <= 1'b0;
      else if (dropHit) winnerGone <= 1'b1;
      if (startScan) wroteSince <= 1'b0;
      else if (ctrlWr) wroteSince <= 1'b1;
    end
  end

  assign scanBusy = scanActive;
endmodule

// File: rtl/mbxDatapath.sv
`timescale 1ns/1ps
module mbxDatapath
  import canArbPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 idxPriority,
  input  logic                 cpuWrEn,
  input  logic [1:0]           cpuSel,
  input  logic [MBX_IDX_W-1:0] cpuMbx,
  input  logic [WORD_W-1:0]    cpuWrData,
  output logic [WORD_W-1:0]    cpuRdData,
  input  logic [TS_W-1:0]      timerVal,
  input  strobeT               st,
  output logic                 bestValid,
  output logic [MBX_IDX_W-1:0] bestIdx,
  output logic                 moValid,
  output logic [MBX_IDX_W-1:0] moMbx,
  output logic [ID_W-1:0]      moId,
  output logic                 moIde,
  output logic                 moRtr,
  output logic [DLC_W-1:0]     moBytes,
  output logic                 noWinner,
  output logic                 irq,
  output logic [MBX_COUNT-1:0] flagVec,
  output logic [MBX_COUNT-1:0] maskVec
);
  logic [CODE_W-1:0] codeMem [MBX_COUNT];
  logic [DLC_W-1:0]  dlcMem  [MBX_COUNT];
  logic              ideMem  [MBX_COUNT];
  logic              rtrMem  [MBX_COUNT];
  logic [ID_W-1:0]   idMem   [MBX_COUNT];
  logic [TS_W-1:0]   tsMem   [MBX_COUNT];

  logic [MBX_COUNT-1:0] ctrlHit, idHit, wbHit, flagClr;
  logic maskWr;
  logic [WORD_W-1:ID_W] unusedBits;

  assign maskWr = cpuWrEn && (cpuSel == SEL_MASK);
  assign unusedBits = cpuWrData[WORD_W-1:ID_W];

  for (genvar m = 0; m < MBX_COUNT; m++) begin : g_hit
    assign ctrlHit[m] = cpuWrEn && (cpuSel == SEL_CTRL) && (cpuMbx == MBX_IDX_W'(m));
    assign idHit[m]   = cpuWrEn && (cpuSel == SEL_ID) && (cpuMbx == MBX_IDX_W'(m));
    assign wbHit[m]   = st.wbEn && (moMbx == MBX_IDX_W'(m));
    assign flagClr[m] = cpuWrEn && (cpuSel == SEL_FLAG) && cpuWrData[m];
  end

  // Mailbox storage: CPU writes, plus completion write-back.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MBX_COUNT; i++) begin
        codeMem[i] <= CODE_INACTIVE;
        dlcMem[i]  <= '0;
        ideMem[i]  <= 1'b0;
        rtrMem[i]  <= 1'b0;
        idMem[i]   <= '0;
        tsMem[i]   <= '0;
      end
      flagVec <= '0;
      maskVec <= '0;
    end else begin
      for (int i = 0; i < MBX_COUNT; i++) begin
        if (ctrlHit[i]) begin
          codeMem[i] <= cpuWrData[CODE_LSB +: CODE_W];
          dlcMem[i]  <= cpuWrData[DLC_LSB +: DLC_W];
          ideMem[i]  <= cpuWrData[IDE_BIT];
          rtrMem[i]  <= cpuWrData[RTR_BIT];
        end else if (wbHit[i]) begin
          codeMem[i] <= CODE_TX_IDLE;
          tsMem[i]   <= timerVal;
        end
        if (idHit[i]) idMem[i] <= cpuWrData[ID_W-1:0];
        flagVec[i] <= wbHit[i] || (flagVec[i] && !flagClr[i]);
        if (maskWr) maskVec[i] <= cpuWrData[i];
      end
    end
  end

  // One mailbox per step compared against the running best.
  logic [KEY_W-1:0] bestKey, curKey, nextKey;
  logic [MBX_IDX_W-1:0] curIdx, nextIdx;
  logic curPend, take, nextValid;

  always_comb begin
    curIdx  = st.scanIdx;
    curPend = (codeMem[curIdx] == CODE_TX_PEND) && !ctrlHit[curIdx];
    curKey  = wireKey(idMem[curIdx], ideMem[curIdx], rtrMem[curIdx]);
    take    = st.scanStep && curPend &&
              (!bestValid || (!idxPriority && (curKey < bestKey)));
    nextValid = bestValid || take;
    nextIdx   = take ? curIdx : bestIdx;
    nextKey   = take ? curKey : bestKey;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestValid <= 1'b0;
      bestIdx   <= '0;
      bestKey   <= '0;
    end else if (st.scanClear) begin
      bestValid <= 1'b0;
    end else if (st.scanStep) begin
      bestValid <= nextValid;
      bestIdx   <= nextIdx;
      bestKey   <= nextKey;
    end
  end

  // Hidden serial buffer (move-out copy).
  logic [DLC_W-1:0] smbDlc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      moValid  <= 1'b0;
      moMbx    <= '0;
      moId     <= '0;
      moIde    <= 1'b0;
      moRtr    <= 1'b0;
      smbDlc   <= '0;
      noWinner <= 1'b0;
    end else if (st.scanFinish) begin
      if (nextValid) begin
        moValid  <= 1'b1;
        moMbx    <= nextIdx;
        moId     <= idMem[nextIdx];
        moIde    <= ideMem[nextIdx];
        moRtr    <= rtrMem[nextIdx];
        smbDlc   <= dlcMem[nextIdx];
        noWinner <= 1'b0;
      end else begin
        moValid  <= 1'b0;
        noWinner <= 1'b1;
      end
    end else if (st.moDrop || st.wbEn) begin
      moValid <= 1'b0;
    end
  end

  assign moBytes = (smbDlc > MAX_BYTES) ? MAX_BYTES : smbDlc;
  assign irq = |(flagVec & maskVec);

  always_comb begin
    cpuRdData = '0;
    case (cpuSel)
      SEL_CTRL: begin
        cpuRdData[DLC_LSB +: DLC_W]   = dlcMem[cpuMbx];
        cpuRdData[CODE_LSB +: CODE_W] = codeMem[cpuMbx];
        cpuRdData[IDE_BIT]            = ideMem[cpuMbx];
        cpuRdData[RTR_BIT]            = rtrMem[cpuMbx];
        cpuRdData[TS_LSB +: TS_W]     = tsMem[cpuMbx];
      end
      SEL_ID:   cpuRdData[ID_W-1:0] = idMem[cpuMbx];
      SEL_FLAG: cpuRdData[MBX_COUNT-1:0] = flagVec;
      default:  cpuRdData[MBX_COUNT-1:0] = maskVec;
    endcase
  end
endmodule

// File: rtl/canTxMailboxArbiter.sv
`timescale 1ns/1ps
module canTxMailboxArbiter
  import canArbPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 idxPriority,
  input  logic [2:0]           phase,
  input  logic                 cpuWrEn,
  input  logic [1:0]           cpuSel,
  input  logic [MBX_IDX_W-1:0] cpuMbx,
  input  logic [WORD_W-1:0]    cpuWrData,
  output logic [WORD_W-1:0]    cpuRdData,
  input  logic [TS_W-1:0]      timerVal,
  input  logic                 txDone,
  output logic                 scanBusy,
  output logic                 moValid,
  output logic [MBX_IDX_W-1:0] moMbx,
  output logic [ID_W-1:0]      moId,
  output logic                 moIde,
  output logic                 moRtr,
  output logic [DLC_W-1:0]     moBytes,
  output logic                 noWinner,
  output logic                 irq
);
  strobeT stb;
  logic bestValid;
  logic [MBX_IDX_W-1:0] bestIdx;
  logic [MBX_COUNT-1:0] flagVec, maskVec;
  logic stbClear, stbFinish;

  assign stbClear  = stb.scanClear;
  assign stbFinish = stb.scanFinish;

  mbxControl ctrl_i (
    .clk(clk), .rstN(rstN), .phase(phaseT'(phase)),
    .cpuWrEn(cpuWrEn), .cpuSel(cpuSel), .cpuMbx(cpuMbx), .txDone(txDone),
    .bestValid(bestValid), .bestIdx(bestIdx), .moValid(moValid), .moMbx(moMbx),
    .noWinner(noWinner), .st(stb), .scanBusy(scanBusy)
  );

  mbxDatapath dp_i (
    .clk(clk), .rstN(rstN), .idxPriority(idxPriority),
    .cpuWrEn(cpuWrEn), .cpuSel(cpuSel), .cpuMbx(cpuMbx), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .timerVal(timerVal), .st(stb),
    .bestValid(bestValid), .bestIdx(bestIdx), .moValid(moValid), .moMbx(moMbx),
    .moId(moId), .moIde(moIde), .moRtr(moRtr), .moBytes(moBytes),
    .noWinner(noWinner), .irq(irq), .flagVec(flagVec), .maskVec(maskVec)
  );
endmodule

// File: rtl/mbxArbChecker.sv
`timescale 1ns/1ps
module mbxArbChecker
  import canArbPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 scanBusy,
  input logic                 stbClear,
  input logic                 stbFinish,
  input logic                 moValid,
  input logic [MBX_IDX_W-1:0] moMbx,
  input logic [DLC_W-1:0]     moBytes,
  input logic                 noWinner,
  input logic                 txDone,
  input logic                 cpuWrEn,
  input logic [1:0]           cpuSel,
  input logic [MBX_IDX_W-1:0] cpuMbx,
  input logic [MBX_COUNT-1:0] flagVec
);
  logic [MBX_IDX_W:0] busyCnt;
  logic dropReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (stbClear) busyCnt <= '0;
    else if (scanBusy) busyCnt <= busyCnt + 1'b1;
  end

  assign dropReq = cpuWrEn && (cpuSel == SEL_CTRL) && moValid && (cpuMbx == moMbx);

  AST_SCAN_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(scanBusy) |-> (busyCnt == (MBX_IDX_W+1)'(MBX_COUNT))); // R9
  AST_SCAN_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(scanBusy) |-> (moValid != noWinner)); // R14
  AST_DROP_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    (dropReq && !stbFinish) |=> !moValid); // R10
  AST_TX_WRITEBACK: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && moValid && !dropReq && !stbFinish) |=> (!moValid && flagVec[$past(moMbx)])); // R12
  AST_BYTE_CAP: assert property (@(posedge clk) disable iff (!rstN)
    moValid |-> (moBytes <= MAX_BYTES)); // R11
endmodule

bind canTxMailboxArbiter mbxArbChecker chk_i (
  .clk(clk), .rstN(rstN), .scanBusy(scanBusy), .stbClear(stbClear),
  .stbFinish(stbFinish), .moValid(moValid), .moMbx(moMbx), .moBytes(moBytes),
  .noWinner(noWinner), .txDone(txDone), .cpuWrEn(cpuWrEn), .cpuSel(cpuSel),
  .cpuMbx(cpuMbx), .flagVec(flagVec)
);

// File: tb/canTxMailboxArbiter_tb_top.sv
`timescale 1ns/1ps
module canTxMailboxArbiter_tb_top;
  localparam int N = 16;
  localparam logic [2:0] P_IDLE = 3'd0, P_FIELD = 3'd1, P_CRC = 3'd2, P_ERR = 3'd3,
                         P_INTER = 3'd4, P_FREEZE = 3'd6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idxPriority = 1'b0;
  logic [2:0] phase = P_FIELD;
  logic cpuWrEn = 1'b0;
  logic [1:0] cpuSel = 2'd0;
  logic [3:0] cpuMbx = 4'd0;
  logic [31:0] cpuWrData = '0;
  logic [31:0] cpuRdData;
  logic [15:0] timerVal = '0;
  logic txDone = 1'b0;
  logic scanBusy, moValid, moIde, moRtr, noWinner, irq;
  logic [3:0] moMbx, moBytes;
  logic [28:0] moId;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [3:0]  mCode [N];
  logic [28:0] mId   [N];
  logic        mIde  [N];
  logic        mRtr  [N];
  logic [3:0]  mDlc  [N];
  logic [15:0] mTs   [N];

  always #2 clk = ~clk;

  canTxMailboxArbiter dut_i (
    .clk(clk), .rstN(rstN), .idxPriority(idxPriority), .phase(phase),
    .cpuWrEn(cpuWrEn), .cpuSel(cpuSel), .cpuMbx(cpuMbx), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .timerVal(timerVal), .txDone(txDone),
    .scanBusy(scanBusy), .moValid(moValid), .moMbx(moMbx), .moId(moId),
    .moIde(moIde), .moRtr(moRtr), .moBytes(moBytes), .noWinner(noWinner), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] benchKey(input logic [28:0] id, input logic ide,
                                           input logic rtr);
    if (ide) return {id[28:18], 1'b1, 1'b1, id[17:0], rtr};
    return {id[28:18], rtr, 1'b0, 18'b0, 1'b0};
  endfunction

  function automatic int expWinner(input bit byIdx);
    int best = -1;
    for (int i = 0; i < N; i++) begin
      if (mCode[i] == 4'b1100) begin
        if (best < 0) best = i;
        else if (!byIdx && benchKey(mId[i], mIde[i], mRtr[i]) <
                           benchKey(mId[best], mIde[best], mRtr[best])) best = i;
      end
    end
    return best;
  endfunction

  task automatic cpuWrite(input logic [1:0] sel, input int mbx, input logic [31:0] data);
    @(negedge clk);
    cpuWrEn = 1'b1; cpuSel = sel; cpuMbx = 4'(mbx); cpuWrData = data;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic cpuRead(input logic [1:0] sel, input int mbx, output logic [31:0] data);
    @(negedge clk);
    cpuSel = sel; cpuMbx = 4'(mbx);
    #1 data = cpuRdData;
  endtask

  task automatic setMbx(input int i, input logic [3:0] code, input logic [28:0] id,
                        input logic ide, input logic rtr, input logic [3:0] dlc);
    cpuWrite(2'd1, i, {3'b0, id});
    cpuWrite(2'd0, i, {16'h0, 6'b0, rtr, ide, code, dlc});
    mCode[i] = code; mId[i] = id; mIde[i] = ide; mRtr[i] = rtr; mDlc[i] = dlc;
  endtask

  task automatic clearAll();
    for (int i = 0; i < N; i++) setMbx(i, 4'b0000, '0, 1'b0, 1'b0, 4'd0);
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!scanBusy) break;
    end
  endtask

  // Triggers a scan with an entry edge and checks R9 timing.
  task automatic runScan(input logic [2:0] trig);
    logic busyMid;
    @(negedge clk) phase = trig;
    repeat (16) @(posedge clk);
    @(negedge clk);
    busyMid = scanBusy;
    phase = P_FIELD;
    @(posedge clk);
    @(negedge clk);
    check(busyMid == 1'b1 && scanBusy == 1'b0, "R9 scan length", {busyMid, scanBusy}, 2'b10);
  endtask

  task automatic checkWinner(input bit byIdx, input string req);
    int w = expWinner(byIdx);
    if (w < 0) begin
      check(noWinner == 1'b1 && moValid == 1'b0, {req, " R14 none pending"},
            {noWinner, moValid}, 2'b10);
    end else begin
      logic [3:0] eb = (mDlc[w] > 4'd8) ? 4'd8 : mDlc[w];
      check(moValid && !noWinner && moMbx == 4'(w), {req, " winner"}, moMbx, w);
      check(moId == mId[w] && moIde == mIde[w] && moRtr == mRtr[w] && moBytes == eb,
            {req, " R11 move-out"}, {moId, moIde, moRtr, moBytes},
            {mId[w], mIde[w], mRtr[w], eb});
    end
  endtask

  task automatic sendDone(input logic [15:0] t);
    int w = moMbx;
    @(negedge clk);
    txDone = 1'b1; timerVal = t;
    @(negedge clk);
    txDone = 1'b0;
    mCode[w] = 4'b1000; mTs[w] = t;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] t;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      mCode[i] = '0; mId[i] = '0; mIde[i] = 0; mRtr[i] = 0; mDlc[i] = '0; mTs[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!moValid && !noWinner && !scanBusy && !irq, "R1 reset outputs",
          {moValid, noWinner, scanBusy, irq}, 4'b0);
    cpuRead(2'd0, 7, rd); check(rd == 0, "R1 ctrl word zero", rd, 0);
    cpuRead(2'd2, 0, rd); check(rd == 0, "R1 flags zero", rd, 0);

    // R14 / R4: nothing pending, then only non-pending codes
    runScan(P_CRC);
    checkWinner(1'b0, "R14 empty bank");
    setMbx(1, 4'b1000, 29'h10, 0, 0, 4'd2);
    setMbx(2, 4'b0100, 29'h20, 0, 0, 4'd2);
    setMbx(9, 4'b1100, 29'h1FFFFFFF, 1, 0, 4'd3);
    runScan(P_CRC);
    check(moValid && moMbx == 4'd9, "R4 only pending code 1100 arbitrates", moMbx, 9);

    // R2: IDE and RTR positions in the key
    clearAll();
    setMbx(2, 4'b1100, {11'h123, 18'h00000}, 1, 0, 4'd8);
    setMbx(5, 4'b1100, {11'h123, 18'h3FFFF}, 0, 0, 4'd8);
    runScan(P_CRC);
    check(moMbx == 4'd5, "R2 standard beats extended with same base", moMbx, 5);
    setMbx(3, 4'b1100, {11'h123, 18'h0}, 0, 1, 4'd1);
    setMbx(8, 4'b1100, {11'h123, 18'h0}, 0, 0, 4'd1);
    setMbx(5, 4'b0000, '0, 0, 0, 4'd0);
    runScan(P_CRC);
    check(moMbx == 4'd8, "R2 data frame beats remote frame", moMbx, 8);
    checkWinner(1'b0, "R2");

    // R3 index mode on same bank
    @(negedge clk) idxPriority = 1'b1;
    runScan(P_CRC);
    check(moMbx == 4'd2, "R3 lowest pending index", moMbx, 2);
    @(negedge clk) idxPriority = 1'b0;

    // R5 ties
    clearAll();
    setMbx(7, 4'b1100, 29'h0ABCDEF, 1, 0, 4'd4);
    setMbx(3, 4'b1100, 29'h0ABCDEF, 1, 0, 4'd4);
    runScan(P_ERR);
    check(moMbx == 4'd3, "R5 tie goes to lower index (R6 error delimiter start)", moMbx, 3);

    // R11 byte cap
    clearAll();
    setMbx(4, 4'b1100, 29'h5, 0, 0, 4'd15);
    runScan(P_CRC);
    check(moBytes == 4'd8, "R11 DLC above 8 capped", moBytes, 8);
    setMbx(4, 4'b1100, 29'h5, 0, 0, 4'd5);
    runScan(P_CRC);
    check(moBytes == 4'd5, "R11 DLC below 8 kept", moBytes, 5);

    // R7: intermission conditions
    clearAll();
    runScan(P_CRC);
    @(negedge clk) phase = P_INTER;
    @(negedge clk);
    check(scanBusy == 1'b0, "R7 no scan without condition", scanBusy, 0);
    phase = P_FIELD;
    setMbx(6, 4'b1100, 29'h77, 0, 0, 4'd1);
    @(negedge clk) phase = P_INTER;
    @(negedge clk);
    check(scanBusy == 1'b1, "R7 scan after write with no winner", scanBusy, 1);
    phase = P_FIELD;
    waitIdle();
    check(moValid && moMbx == 4'd6, "R7 winner found", moMbx, 6);
    // R10 drop moved-out winner, then R7 winner-gone rescan
    setMbx(6, 4'b1100, 29'h78, 0, 0, 4'd1);
    check(moValid == 1'b0, "R10 write to winner drops move-out", moValid, 0);
    @(negedge clk) phase = P_INTER;
    @(negedge clk);
    check(scanBusy == 1'b1, "R7 scan after winner dropped", scanBusy, 1);
    phase = P_FIELD;
    waitIdle();
    check(moValid && moId == 29'h78, "R7 rescan picks rewritten mailbox", moId, 29'h78);

    // R8 idle write and freeze exit
    @(negedge clk) phase = P_IDLE;
    cpuWrite(2'd0, 2, {22'h0, 1'b0, 1'b0, 4'b1100, 4'd1});
    mCode[2] = 4'b1100; mId[2] = '0; mIde[2] = 0; mRtr[2] = 0; mDlc[2] = 4'd1;
    check(scanBusy == 1'b1, "R8 idle control write starts scan", scanBusy, 1);
    waitIdle();
    phase = P_FIELD;
    check(moMbx == 4'd2, "R8 idle scan winner", moMbx, 2);
    @(negedge clk) phase = P_FREEZE;
    repeat (2) @(negedge clk);
    check(scanBusy == 1'b0, "R8 no scan while frozen", scanBusy, 0);
    phase = P_FIELD;
    @(negedge clk);
    check(scanBusy == 1'b1, "R8 freeze exit starts scan", scanBusy, 1);
    waitIdle();

    // R10 mid-scan deactivation of the current best restarts the scan
    clearAll();
    setMbx(1, 4'b1100, {11'h010, 18'h0}, 0, 0, 4'd1);
    setMbx(4, 4'b1100, {11'h020, 18'h0}, 0, 0, 4'd1);
    @(negedge clk) phase = P_CRC;
    repeat (4) @(posedge clk);
    cpuWrite(2'd0, 1, 32'h0);
    mCode[1] = 4'b0000; mDlc[1] = 0;
    phase = P_FIELD;
    waitIdle();
    check(moValid && moMbx == 4'd4, "R10 killed best never moved out", moMbx, 4);

    // R12 / R13 write-back, flag, mask, w1c
    t = 16'h1234;
    sendDone(t);
    check(moValid == 1'b0, "R12 moValid clears after send", moValid, 0);
    cpuRead(2'd0, 4, rd);
    check(rd[31:16] == t && rd[7:4] == 4'b1000, "R12 timestamp and code",
          {rd[31:16], rd[7:4]}, {t, 4'b1000});
    cpuRead(2'd2, 0, rd);
    check(rd[15:0] == 16'h0010, "R12 flag bit set", rd, 16'h0010);
    check(irq == 1'b0, "R13 irq masked off", irq, 0);
    cpuWrite(2'd3, 0, 32'h0000_0010);
    @(negedge clk);
    check(irq == 1'b1, "R13 irq when mask set", irq, 1);
    cpuWrite(2'd2, 0, 32'h0000_0001);
    check(irq == 1'b1, "R13 clearing other flag keeps irq", irq, 1);
    cpuWrite(2'd2, 0, 32'h0000_0010);
    check(irq == 1'b0, "R13 w1c clears irq", irq, 0);
    cpuWrite(2'd3, 0, 32'h0);

    // Random banks in both modes
    for (int it = 0; it < 120; it++) begin
      bit byIdx = 1'($urandom_range(0, 1));
      for (int i = 0; i < N; i++) begin
        int sel = $urandom_range(0, 5);
        logic [3:0] code = (sel < 2) ? 4'b1100 : (sel == 2) ? 4'b1000 :
                           (sel == 3) ? 4'b0000 : 4'($urandom_range(0, 11));
        logic [28:0] id = 29'($urandom);
        if ($urandom_range(0, 3) == 0) id[28:18] = 11'h155;
        setMbx(i, code, id, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               4'($urandom_range(0, 15)));
      end
      @(negedge clk) idxPriority = byIdx;
      runScan(($urandom_range(0, 1) == 1) ? P_CRC : P_ERR);
      checkWinner(byIdx, byIdx ? "R3 random" : "R2 random");
      if (moValid && $urandom_range(0, 2) == 0) begin
        int w = moMbx;
        t = 16'($urandom);
        sendDone(t);
        cpuRead(2'd0, w, rd);
        check(rd[31:16] == t && rd[7:4] == 4'b1000, "R12 random write-back",
              {rd[31:16], rd[7:4]}, {t, 4'b1000});
      end
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule